// File: doc/BRIEF.md
# PLL Configuration Word Calculator

This block turns two numbers, a wanted per-lane serial bit rate in kbps and a reference clock frequency in kHz, into a 16-bit PLL setup word. It works out the word in several steps. First it picks an input pre-divider that keeps the divided reference at or above 5 MHz. Next it takes the smallest feedback multiplier that reaches the wanted rate. From the exact output frequency it then chooses a VCO band code. Finally it reports the output frequency as the packed word itself would decode.

A request is taken on a one-cycle `start` while the block is idle. The block is `busy` while it works and gives one `done` pulse when the result is ready. All arithmetic uses one shared restoring shift-subtract divider that resolves one quotient bit per cycle. The pre-divider search needs no division, because it steps a running threshold. A zero reference is refused with an error flag.

Top module: `pllcw_calc`

## Requirements
- R1: When `start` is taken with `ref_khz` equal to 0, `done` and `err` are high in the next cycle, `busy` stays low, and `cfg_word` and `achieved_khz` are both 0.
- R2: The pre-divider d is the smallest value, counting up from 1, for which floor(ref/(d+1)) < 5000. It is placed in `cfg_word[12:8]`.
- R3: The pre-divider never exceeds 31. A reference large enough to need more gives 31.
- R4: The multiplier m is ceil(rate·d / ref). Its low 8 bits appear in `cfg_word[7:0]`, and `cfg_word[13]` is 0.
- R5: `cfg_word[15:14]` holds the band code, computed from the exact value F = floor(ref·m/d) with the full-width m: 3 if F ≥ 501000, else 2 if F ≥ 251000, else 1 if F ≥ 126000, else 0.
- R6: `achieved_khz` equals floor(ref·m8/d), where m8 is `cfg_word[7:0]` read as 1 when it is 0.
- R7: A `start` taken while idle raises `busy` in the next cycle (R1 excepted). `done` is a single-cycle pulse during which `busy` is low. A `start` while `busy` is ignored, and the request in progress completes unchanged.
- R8: `cfg_word`, `achieved_khz` and `err` change only in a cycle where `done` is high. They hold their values until the next result.
- R9: After reset, `busy`, `done`, `err`, `cfg_word` and `achieved_khz` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only while idle |
| rate_kbps | input | 24 | Wanted per-lane bit rate in kbps |
| ref_khz | input | 24 | Reference clock frequency in kHz |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Last request had a zero reference |
| cfg_word | output | 16 | Packed band, pre-divider and multiplier |
| achieved_khz | output | 32 | Output frequency decoded from the word |

## Verification
The assertions cover the handshake on every cycle. They check that `done` is a lone pulse with `busy` low, that `busy` only rises after a `start`, and that results hold between pulses. They also check that an error result is all zero and that a good result never has a zero pre-divider field. The arithmetic itself can only be shown by the bench scenarios, which compare results against an independent model. These scenarios cover the search stopping early or saturating at 31, band edges hit exactly, a multiplier wider than its field, a zero rate, and a start issued mid-computation.

// File: rtl/pllcw_pkg.sv
package pllcw_pkg;

    localparam int DIV_W  = 5;
    localparam int MUL_W  = 8;
    localparam int BAND_W = 2;
    localparam int WORD_W = 16;

    localparam logic [DIV_W-1:0] DIV_MAX = 5'd31;

    localparam int BAND3_KHZ = 501000;
    localparam int BAND2_KHZ = 251000;
    localparam int BAND1_KHZ = 126000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_MUL,
        ST_EXACT,
        ST_DECODE
    } pllcw_state_e;

    typedef struct packed {
        logic [BAND_W-1:0] band;
        logic              spare;
        logic [DIV_W-1:0]  div;
        logic [MUL_W-1:0]  mul;
    } pllcw_word_t;

    function automatic pllcw_word_t pack_word(logic [BAND_W-1:0] band,
                                              logic [DIV_W-1:0]  div,
                                              logic [MUL_W-1:0]  mul);
        pllcw_word_t w;
        w.band  = band;
        w.spare = 1'b0;
        w.div   = div;
        w.mul   = mul;
        return w;
    endfunction

    function automatic logic [MUL_W-1:0] nz_mul(logic [MUL_W-1:0] f);
        return (f == '0) ? MUL_W'(1) : f;
    endfunction

    function automatic logic [DIV_W-1:0] nz_div(logic [DIV_W-1:0] f);
        return (f == '0) ? DIV_W'(1) : f;
    endfunction

endpackage

// File: rtl/pllcw_dsearch.sv
module pllcw_dsearch
    import pllcw_pkg::*;
#(
    parameter int REF_W = 24,
    parameter int STEP  = 5000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [REF_W-1:0] ref_khz,
    output logic [DIV_W-1:0] div_out,
    output logic             done
);
    localparam int TH_W = REF_W + DIV_W;

    logic [TH_W-1:0] thr;
    logic            act;
    logic            stop;

    assign stop = (div_out == DIV_MAX) || (TH_W'(ref_khz) < thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_out <= '0;
            thr     <= '0;
            act     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                div_out <= DIV_W'(1);
                thr     <= TH_W'(2 * STEP);
                act     <= 1'b1;
            end else if (act) begin
                if (stop) begin
                    act  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    div_out <= div_out + DIV_W'(1);
                    thr     <= thr + TH_W'(STEP);
                end
            end
        end
    end
endmodule

// File: rtl/pllcw_rdiv.sv
module pllcw_rdiv #(
    parameter int N = 54,
    parameter int D = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [N-1:0] dividend,
    input  logic [D-1:0] divisor,
    output logic [N-1:0] quotient,
    output logic         done
);
    localparam int CNT_W = $clog2(N + 1);

    logic [D-1:0]     rem;
    logic [CNT_W-1:0] cnt;
    logic             act;
    logic [D:0]       trial;
    logic [D:0]       diff;
    logic             fits;

    always_comb begin
        trial = {rem, quotient[N-1]};
        fits  = trial >= {1'b0, divisor};
        diff  = trial - {1'b0, divisor};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem      <= '0;
            quotient <= '0;
            cnt      <= '0;
            act      <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem      <= '0;
                quotient <= dividend;
                cnt      <= CNT_W'(N);
                act      <= 1'b1;
            end else if (act) begin
                rem      <= fits ? diff[D-1:0] : trial[D-1:0];
                quotient <= {quotient[N-2:0], fits};
                cnt      <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    act  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pllcw_band.sv
module pllcw_band
    import pllcw_pkg::*;
#(
    parameter int W = 54
) (
    input  logic [W-1:0]      freq_khz,
    output logic [BAND_W-1:0] band
);
    always_comb begin
        if (freq_khz >= W'(BAND3_KHZ))      band = 2'd3;
        else if (freq_khz >= W'(BAND2_KHZ)) band = 2'd2;
        else if (freq_khz >= W'(BAND1_KHZ)) band = 2'd1;
        else                                band = 2'd0;
    end
endmodule

// File: rtl/pllcw_calc.sv
module pllcw_calc
    import pllcw_pkg::*;
#(
    parameter int RATE_W       = 24,
    parameter int REF_W        = 24,
    parameter int MIN_POST_KHZ = 5000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [RATE_W-1:0]        rate_kbps,
    input  logic [REF_W-1:0]         ref_khz,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic [WORD_W-1:0]        cfg_word,
    output logic [REF_W+MUL_W-1:0]   achieved_khz
);
    localparam int NUM_W  = RATE_W + DIV_W + 1;
    localparam int PROD_W = REF_W + NUM_W;
    localparam int ACH_W  = REF_W + MUL_W;

    pllcw_state_e      state;
    logic [RATE_W-1:0] rate_q;
    logic [REF_W-1:0]  ref_q;
    logic [DIV_W-1:0]  div_q;
    logic [NUM_W-1:0]  mul_q;
    logic [BAND_W-1:0] band_q;

    logic              srch_go, srch_done;
    logic [DIV_W-1:0]  srch_div;
    logic              dv_go, dv_done;
    logic [PROD_W-1:0] dv_a, dv_quo;
    logic [REF_W-1:0]  dv_b;
    logic [BAND_W-1:0] band_now;

    pllcw_dsearch #(.REF_W(REF_W), .STEP(MIN_POST_KHZ)) u_search (
        .clk(clk), .rst(rst), .go(srch_go), .ref_khz(ref_q),
        .div_out(srch_div), .done(srch_done)
    );

    pllcw_rdiv #(.N(PROD_W), .D(REF_W)) u_div (
        .clk(clk), .rst(rst), .go(dv_go), .dividend(dv_a), .divisor(dv_b),
        .quotient(dv_quo), .done(dv_done)
    );

    pllcw_band #(.W(PROD_W)) u_band (
        .freq_khz(dv_quo), .band(band_now)
    );

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            rate_q       <= '0;
            ref_q        <= '0;
            div_q        <= '0;
            mul_q        <= '0;
            band_q       <= '0;
            srch_go      <= 1'b0;
            dv_go        <= 1'b0;
            dv_a         <= '0;
            dv_b         <= '0;
            done         <= 1'b0;
            err          <= 1'b0;
            cfg_word     <= '0;
            achieved_khz <= '0;
        end else begin
            done    <= 1'b0;
            srch_go <= 1'b0;
            dv_go   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        rate_q <= rate_kbps;
                        ref_q  <= ref_khz;
                        if (ref_khz == '0) begin
                            err          <= 1'b1;
                            done         <= 1'b1;
                            cfg_word     <= '0;
                            achieved_khz <= '0;
                        end else begin
                            srch_go <= 1'b1;
                            state   <= ST_SEARCH;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (srch_done) begin
                        div_q <= srch_div;
                        dv_a  <= PROD_W'(rate_q) * PROD_W'(srch_div)
                               + PROD_W'(ref_q) - PROD_W'(1);
                        dv_b  <= ref_q;
                        dv_go <= 1'b1;
                        state <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    if (dv_done) begin
                        mul_q <= dv_quo[NUM_W-1:0];
                        dv_a  <= PROD_W'(ref_q) * PROD_W'(dv_quo[NUM_W-1:0]);
                        dv_b  <= REF_W'(nz_div(div_q));
                        dv_go <= 1'b1;
                        state <= ST_EXACT;
                    end
                end
                ST_EXACT: begin
                    if (dv_done) begin
                        band_q <= band_now;
                        dv_a   <= PROD_W'(ref_q) * PROD_W'(nz_mul(mul_q[MUL_W-1:0]));
                        dv_go  <= 1'b1;
                        state  <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (dv_done) begin
                        achieved_khz <= dv_quo[ACH_W-1:0];
                        cfg_word     <= pack_word(band_q, div_q, mul_q[MUL_W-1:0]);
                        err          <= 1'b0;
                        done         <= 1'b1;
                        state        <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pllcw_calc_chk.sv
module pllcw_calc_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [15:0] cfg_word,
    input logic [31:0] achieved_khz
);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(cfg_word) && $stable(achieved_khz) && $stable(err)));

    // R1
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (cfg_word == 16'd0 && achieved_khz == 32'd0));

    // R2
    div_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (cfg_word[12:8] != 5'd0));
endmodule

bind pllcw_calc pllcw_calc_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .err(err), .cfg_word(cfg_word), .achieved_khz(achieved_khz)
);

// File: tb/pllcw_calc_test.sv
module pllcw_calc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] rate_kbps = '0;
    logic [23:0] ref_khz = '0;
    logic        busy, done, err;
    logic [15:0] cfg_word;
    logic [31:0] achieved_khz;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] word;
        logic [31:0] ach;
        logic        err;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    pllcw_calc uut (
        .clk(clk), .rst(rst), .start(start), .rate_kbps(rate_kbps),
        .ref_khz(ref_khz), .busy(busy), .done(done), .err(err),
        .cfg_word(cfg_word), .achieved_khz(achieved_khz)
    );

    function automatic exp_t model(longint rate, longint rf, string tag);
        exp_t e;
        longint d, m, f, m8, band;
        e.tag = tag;
        if (rf == 0) begin
            e.word = '0; e.ach = '0; e.err = 1'b1;
            return e;
        end
        d = 1;
        while (d < 31 && (rf / (d + 1)) >= 5000) d++;
        m = (rate * d + rf - 1) / rf;
        f = rf * m / d;
        if (f >= 501000)      band = 3;
        else if (f >= 251000) band = 2;
        else if (f >= 126000) band = 1;
        else                  band = 0;
        m8 = m & 255;
        e.word = 16'((band << 14) | (d << 8) | m8);
        if (m8 == 0) m8 = 1;
        e.ach = 32'(rf * m8 / d);
        e.err = 1'b0;
        return e;
    endfunction

    task automatic check(bit ok, string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // monitor: pops the scoreboard on every result pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, $sformatf("R7 unexpected done: word act %h exp none", cfg_word));
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cfg_word == e.word && err == e.err,
                      $sformatf("%s word/err act %h/%0d exp %h/%0d",
                                e.tag, cfg_word, err, e.word, e.err));
                check(achieved_khz == e.ach,
                      $sformatf("%s achieved act %0d exp %0d", e.tag, achieved_khz, e.ach));
                check(!busy, $sformatf("%s R7 busy at done act %0d exp 0", e.tag, busy));
            end
        end
    end

    task automatic run_case(longint rate, longint rf, string tag, bit poke_mid);
        exp_t e;
        e = model(rate, rf, tag);
        while (busy) @(negedge clk);
        sb.push_back(e);
        rate_kbps = 24'(rate);
        ref_khz   = 24'(rf);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (rf == 0)
            check(done && !busy, $sformatf("R1 immediate done act done=%0d busy=%0d exp 1/0", done, busy));
        else
            check(busy, $sformatf("R7 busy after start act %0d exp 1", busy));
        if (poke_mid) begin
            repeat (20) @(negedge clk);
            // R7: start during busy with other operands must be ignored
            rate_kbps = 24'd999;
            ref_khz   = 24'd0;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        // R8: result held after the pulse
        check(cfg_word == e.word && achieved_khz == e.ach && !busy,
              $sformatf("R8 hold act %h/%0d exp %h/%0d", cfg_word, achieved_khz, e.word, e.ach));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9
        check(!busy && !done && !err && cfg_word == 0 && achieved_khz == 0,
              $sformatf("R9 reset act b%0d d%0d e%0d w%h a%0d exp all 0",
                        busy, done, err, cfg_word, achieved_khz));
        run_case(480000, 27000, "R2 R4 R5 R6 typical", 1'b0);
        run_case(300000, 3000, "R2 small ref divider 1", 1'b0);
        run_case(900000, 16000000, "R3 divider clamp", 1'b0);
        run_case(125000, 1000, "R5 band0 edge", 1'b0);
        run_case(126000, 1000, "R5 band1 edge", 1'b0);
        run_case(251000, 1000, "R5 band2 edge", 1'b0);
        run_case(501000, 1000, "R4 R5 R6 wide multiplier band3", 1'b0);
        run_case(0, 24000, "R6 zero multiplier", 1'b0);
        run_case(400000, 0, "R1 zero reference", 1'b0);
        run_case(720000, 19200, "R7 start while busy", 1'b1);
        run_case(256000, 1000, "R6 multiplier field wraps to 0", 1'b0);
        run_case(1000000, 50000, "R2 R5 mid divider", 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule